// File: doc/BRIEF.md
# Serial Controller Interrupt and Status Logic

This block holds the status side of a classic asynchronous serial controller. It assembles the line status byte from the receive FIFO fill level, the receive error events and the transmitter state. It assembles the modem status byte from the four modem input pins, with change flags that collect edges until software reads the byte.

Four interrupt sources are weighed against a four-bit enable value: line errors, received data, transmitter empty and modem change. The source with the highest priority is encoded into an identification byte, and a single interrupt output is driven. The received-data source follows a selectable FIFO fill threshold when FIFO mode is on. Reads of the three status bytes come in as one-cycle strobes and carry the clearing side effects. Serialization and FIFO storage are outside this block.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, with all inputs idle, `iir_o` is 0x01, `irq_o` is 0, `lsr_o` is 0x00 and `msr_o` is 0x00.
- R2: `lsr_o` bit 0 is 1 when `rx_level_i` is non-zero. Bit 5 follows `thr_empty_i`, bit 6 follows `tx_idle_i` and bit 7 follows `rx_err_any_i`.
- R3: A one-cycle pulse on the overrun, parity, framing or break input sets `lsr_o` bit 1, 2, 3 or 4 respectively. The bit holds until a cycle with `lsr_rd_i` high clears it. An event that arrives in the same cycle as the read survives the read.
- R4: `msr_o` bits 7, 6, 5 and 4 show `dcd_i`, `ri_i`, `dsr_i` and `cts_i` after SYNC_STAGES clock edges.
- R5: `msr_o` bits 0, 1 and 3 latch any change of the synchronized `cts_i`, `dsr_i` and `dcd_i`. Bit 2 latches only a 1-to-0 change of `ri_i`. All four bits clear on a cycle with `msr_rd_i` high.
- R6: Received data is pending when FIFO mode is off and `rx_level_i` is at least 1. With FIFO mode on, it is pending when `rx_level_i` reaches the threshold picked by `trig_sel_i`: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14 bytes.
- R7: `iir_o` bit 0 is 1 when nothing is pending. Bits 2:1 name the source in fixed priority: 11 for line error (highest), 10 for received data, 01 for transmitter empty and 00 for modem change (lowest).
- R8: `iir_o` bits 7:6 are 11 when `fifo_en_i` is 1 and 00 when it is 0. Bits 5:3 are 0.
- R9: A rising edge of `thr_empty_i` makes the transmitter-empty source pending. `thr_write_i` clears it. An `iir_rd_i` strobe clears it only while it is the reported source.
- R10: `irq_o` is 1 exactly when `iir_o` bit 0 is 0. A source whose `ier_i` bit is 0 (bit 0 data, 1 transmitter, 2 line, 3 modem) is neither reported nor raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_i | input | 4 | Interrupt source enables |
| fifo_en_i | input | 1 | FIFO mode on |
| trig_sel_i | input | 2 | Receive threshold select |
| rx_level_i | input | LVL_W | Receive FIFO fill count |
| rx_err_any_i | input | 1 | Some entry in the receive FIFO carries an error |
| ovr_err_i | input | 1 | Overrun event pulse |
| par_err_i | input | 1 | Parity error event pulse |
| frm_err_i | input | 1 | Framing error event pulse |
| brk_err_i | input | 1 | Break event pulse |
| thr_empty_i | input | 1 | Transmit holding buffer empty |
| tx_idle_i | input | 1 | Transmitter fully idle |
| thr_write_i | input | 1 | Transmit buffer write strobe |
| cts_i | input | 1 | Clear-to-send pin, active sense |
| dsr_i | input | 1 | Data-set-ready pin, active sense |
| ri_i | input | 1 | Ring indicator pin, active sense |
| dcd_i | input | 1 | Carrier detect pin, active sense |
| lsr_rd_i | input | 1 | Line status read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| iir_rd_i | input | 1 | Identification read strobe |
| lsr_o | output | 8 | Line status byte |
| msr_o | output | 8 | Modem status byte |
| iir_o | output | 8 | Interrupt identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every threshold setting just below and at its level. A comparison that is off by one, or a threshold that is not ignored when FIFO mode is off, raises or holds back the data interrupt in the wrong row. Several sources are stacked at once to check the priority order. A wrong order reports data or the transmitter while a line error is pending.

The bench reads the identification byte while the transmitter source is pending but hidden behind received data. A design that clears on every such read loses that interrupt. An error pulse is placed on the same cycle as a status read, and a read that wins over the event drops the error. The ring indicator is raised and then dropped: a design that flags the rising edge, or that flags both edges, shows bit 2 at the wrong time.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   typedef enum logic [1:0] {
      SRC_MODEM = 2'b00,
      SRC_THRE  = 2'b01,
      SRC_RDA   = 2'b10,
      SRC_LINE  = 2'b11
   } irq_src_e;

   localparam int NUM_ERR   = 4;
   localparam int NUM_MODEM = 4;
   localparam int MAX_TRIG  = 14;

   function automatic int trig_bytes(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction
endpackage

// File: rtl/uart_lsr_unit.sv
module uart_lsr_unit
   import uart_irq_pkg::*;
#(
   parameter int LVL_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LVL_W-1:0]     rx_level,
   input  logic                 rx_err_any,
   input  logic [NUM_ERR-1:0]   err_ev,
   input  logic                 thr_empty,
   input  logic                 tx_idle,
   input  logic                 rd,
   output logic [7:0]           lsr,
   output logic                 line_pend
);
   logic [NUM_ERR-1:0] sticky_q;

   for (genvar i = 0; i < NUM_ERR; i++) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          sticky_q[i] <= 1'b0;
         else if (err_ev[i])  sticky_q[i] <= 1'b1;
         else if (rd)         sticky_q[i] <= 1'b0;
      end
   end

   assign lsr       = {rx_err_any, tx_idle, thr_empty, sticky_q, (rx_level != '0)};
   assign line_pend = |sticky_q;
endmodule

// File: rtl/uart_msr_unit.sv
module uart_msr_unit
   import uart_irq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_MODEM-1:0]  pins,
   input  logic                  rd,
   output logic [7:0]            msr,
   output logic                  modem_pend
);
   localparam int RI_IDX = 2;

   logic [NUM_MODEM-1:0] stg_q [SYNC_STAGES];
   logic [NUM_MODEM-1:0] cur, prev_q, ev, delta_q;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       stg_q[s] <= '0;
         else if (s == 0)  stg_q[s] <= pins;
         else              stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
   end

   assign cur = stg_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur;
   end

   for (genvar i = 0; i < NUM_MODEM; i++) begin : g_delta
      if (i == RI_IDX) begin : g_trail
         assign ev[i] = prev_q[i] & ~cur[i];
      end else begin : g_any
         assign ev[i] = prev_q[i] ^ cur[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      delta_q[i] <= 1'b0;
         else if (ev[i])  delta_q[i] <= 1'b1;
         else if (rd)     delta_q[i] <= 1'b0;
      end
   end

   assign msr        = {cur, delta_q};
   assign modem_pend = |delta_q;
endmodule

// File: rtl/uart_thre_unit.sv
module uart_thre_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic thr_empty,
   input  logic thr_write,
   input  logic iir_rd,
   input  logic reported,
   output logic pend
);
   logic empty_q;
   logic clr;

   assign clr = thr_write | (iir_rd & reported);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b0;
         pend    <= 1'b0;
      end else begin
         empty_q <= thr_empty;
         if (clr)                        pend <= 1'b0;
         else if (thr_empty && !empty_q) pend <= 1'b1;
      end
   end
endmodule

// File: rtl/uart_irq_encoder.sv
module uart_irq_encoder
   import uart_irq_pkg::*;
(
   input  logic [3:0] ier,
   input  logic       line_pend,
   input  logic       rda_pend,
   input  logic       thre_pend,
   input  logic       modem_pend,
   input  logic       fifo_on,
   output logic [7:0] iir
);
   irq_src_e src;
   logic     any;

   always_comb begin
      any = 1'b1;
      src = SRC_MODEM;
      if (ier[2] && line_pend)       src = SRC_LINE;
      else if (ier[0] && rda_pend)   src = SRC_RDA;
      else if (ier[1] && thre_pend)  src = SRC_THRE;
      else if (ier[3] && modem_pend) src = SRC_MODEM;
      else                           any = 1'b0;
   end

   assign iir = {{2{fifo_on}}, 3'b000, src, ~any};
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
   import uart_irq_pkg::*;
#(
   parameter int LVL_W       = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_FIFO    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       ier_i,
   input  logic             fifo_en_i,
   input  logic [1:0]       trig_sel_i,
   input  logic [LVL_W-1:0] rx_level_i,
   input  logic             rx_err_any_i,
   input  logic             ovr_err_i,
   input  logic             par_err_i,
   input  logic             frm_err_i,
   input  logic             brk_err_i,
   input  logic             thr_empty_i,
   input  logic             tx_idle_i,
   input  logic             thr_write_i,
   input  logic             cts_i,
   input  logic             dsr_i,
   input  logic             ri_i,
   input  logic             dcd_i,
   input  logic             lsr_rd_i,
   input  logic             msr_rd_i,
   input  logic             iir_rd_i,
   output logic [7:0]       lsr_o,
   output logic [7:0]       msr_o,
   output logic [7:0]       iir_o,
   output logic             irq_o
);
   localparam int LVL_MAX = (1 << LVL_W) - 1;

   if (LVL_W < 1 || LVL_MAX < MAX_TRIG) begin : g_bad_lvl
      $error("LVL_W too narrow for the largest receive threshold");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic line_pend, modem_pend, thre_pend, rda_pend, fifo_on, thre_shown;

   uart_lsr_unit #(.LVL_W(LVL_W)) i_lsr (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_level   (rx_level_i),
      .rx_err_any (rx_err_any_i),
      .err_ev     ({brk_err_i, frm_err_i, par_err_i, ovr_err_i}),
      .thr_empty  (thr_empty_i),
      .tx_idle    (tx_idle_i),
      .rd         (lsr_rd_i),
      .lsr        (lsr_o),
      .line_pend  (line_pend)
   );

   uart_msr_unit #(.SYNC_STAGES(SYNC_STAGES)) i_msr (
      .clk        (clk),
      .rst_n      (rst_n),
      .pins       ({dcd_i, ri_i, dsr_i, cts_i}),
      .rd         (msr_rd_i),
      .msr        (msr_o),
      .modem_pend (modem_pend)
   );

   assign thre_shown = (iir_o[3:0] == {1'b0, SRC_THRE, 1'b0});

   uart_thre_unit i_thre (
      .clk       (clk),
      .rst_n     (rst_n),
      .thr_empty (thr_empty_i),
      .thr_write (thr_write_i),
      .iir_rd    (iir_rd_i),
      .reported  (thre_shown),
      .pend      (thre_pend)
   );

   if (HAS_FIFO) begin : g_fifo
      int unsigned thresh;
      assign thresh   = fifo_en_i ? trig_bytes(trig_sel_i) : 1;
      assign rda_pend = (int'(rx_level_i) >= int'(thresh));
      assign fifo_on  = fifo_en_i;
   end else begin : g_nofifo
      assign rda_pend = (rx_level_i != '0);
      assign fifo_on  = 1'b0;
   end

   uart_irq_encoder i_enc (
      .ier        (ier_i),
      .line_pend  (line_pend),
      .rda_pend   (rda_pend),
      .thre_pend  (thre_pend),
      .modem_pend (modem_pend),
      .fifo_on    (fifo_on),
      .iir        (iir_o)
   );

   assign irq_o = ~iir_o[0];
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] ier_i,
   input logic       par_err_i,
   input logic       cts_i,
   input logic       thr_write_i,
   input logic       lsr_rd_i,
   input logic       msr_rd_i,
   input logic [7:0] lsr_o,
   input logic [7:0] msr_o,
   input logic [7:0] iir_o,
   input logic       irq_o
);
   a_r3_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_o[2] && !lsr_rd_i) |=> lsr_o[2]);

   a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd_i && !par_err_i) |=> !lsr_o[2]);

   a_r5_delta_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_o[0] && !msr_rd_i) |=> msr_o[0]);

   a_r7_line_first: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_i[2] && (|lsr_o[4:1])) |-> (iir_o[3:0] == 4'b0110));

   a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      thr_write_i |=> (iir_o[3:0] != 4'b0010));

   a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_i == 4'b0000) |-> !irq_o);

   a_r8_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      iir_o[0] |-> (iir_o[3:1] == 3'b000));
endmodule

bind uart_irq_status uart_irq_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ier_i       (ier_i),
   .par_err_i   (par_err_i),
   .cts_i       (cts_i),
   .thr_write_i (thr_write_i),
   .lsr_rd_i    (lsr_rd_i),
   .msr_rd_i    (msr_rd_i),
   .lsr_o       (lsr_o),
   .msr_o       (msr_o),
   .iir_o       (iir_o),
   .irq_o       (irq_o)
);

// File: tb/test_uart_irq_status.sv
`timescale 1ns/1ps
module test_uart_irq_status;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ier = '0;
   logic       fen = 1'b0;
   logic [1:0] trig = '0;
   logic [4:0] lvl = '0;
   logic       rxany = 1'b0, ovr = 1'b0, par = 1'b0, frm = 1'b0, brk = 1'b0;
   logic       thre = 1'b0, idle = 1'b0, thw = 1'b0;
   logic       cts = 1'b0, dsr = 1'b0, ri = 1'b0, dcd = 1'b0;
   logic       lrd = 1'b0, mrd = 1'b0, ird = 1'b0;
   logic [7:0] lsr, msr, iir;
   logic       irq;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   uart_irq_status i_uart_irq_status (
      .clk(clk), .rst_n(rst_n), .ier_i(ier), .fifo_en_i(fen), .trig_sel_i(trig),
      .rx_level_i(lvl), .rx_err_any_i(rxany), .ovr_err_i(ovr), .par_err_i(par),
      .frm_err_i(frm), .brk_err_i(brk), .thr_empty_i(thre), .tx_idle_i(idle),
      .thr_write_i(thw), .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd),
      .lsr_rd_i(lrd), .msr_rd_i(mrd), .iir_rd_i(ird),
      .lsr_o(lsr), .msr_o(msr), .iir_o(iir), .irq_o(irq)
   );

   // {fifo_en, trig_sel, level, expected irq}; only the data source is enabled
   localparam logic [8:0] VEC [12] = '{
      {1'b0, 2'd3, 5'd0,  1'b0}, {1'b0, 2'd3, 5'd1,  1'b1},
      {1'b1, 2'd0, 5'd0,  1'b0}, {1'b1, 2'd0, 5'd1,  1'b1},
      {1'b1, 2'd1, 5'd3,  1'b0}, {1'b1, 2'd1, 5'd4,  1'b1},
      {1'b1, 2'd2, 5'd7,  1'b0}, {1'b1, 2'd2, 5'd8,  1'b1},
      {1'b1, 2'd3, 5'd13, 1'b0}, {1'b1, 2'd3, 5'd14, 1'b1},
      {1'b1, 2'd3, 5'd20, 1'b1}, {1'b1, 2'd2, 5'd31, 1'b1}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FIFO check FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
      end
   end

   initial begin
      cyc(4);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1 iir", iir, 8'h01);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      chk("R1 lsr", lsr, 8'h00);
      chk("R1 msr", msr, 8'h00);

      // R6 threshold table, R8 fifo bits
      ier = 4'b0001;
      for (int k = 0; k < 12; k++) begin
         {fen, trig, lvl} = VEC[k][8:1];
         cyc(1);
         chk($sformatf("R6 row %0d iir", k), iir,
             {{2{fen}}, 5'b00000, ~VEC[k][0]} | (VEC[k][0] ? 8'h04 : 8'h00));
         chk($sformatf("R10 row %0d irq", k), {7'd0, irq}, {7'd0, VEC[k][0]});
         chk($sformatf("R2 row %0d lsr0", k), {7'd0, lsr[0]}, {7'd0, lvl != 0});
      end
      fen = 1'b0; lvl = 0; ier = 4'b0000;

      // R2 pass-through bits, R10 masking
      thre = 1'b1; idle = 1'b1; rxany = 1'b1; lvl = 5'd2;
      cyc(2);
      chk("R2 lsr", lsr, 8'hE1);
      chk("R10 masked irq", {7'd0, irq}, 8'h00);
      thw = 1'b1; cyc(1); thw = 1'b0;
      idle = 1'b0; rxany = 1'b0; lvl = 0;
      cyc(1);

      // R3 sticky errors
      par = 1'b1; cyc(1); par = 1'b0;
      chk("R3 set", lsr, 8'h24);
      cyc(2);
      chk("R3 hold", lsr, 8'h24);
      lrd = 1'b1; cyc(1); lrd = 1'b0;
      chk("R3 clear", lsr, 8'h20);
      ovr = 1'b1; lrd = 1'b1; cyc(1); ovr = 1'b0; lrd = 1'b0;
      chk("R3 event beats read", lsr, 8'h22);
      lrd = 1'b1; cyc(1); lrd = 1'b0;
      chk("R3 clear again", lsr, 8'h20);

      // R7 priority
      ier = 4'b1111; lvl = 5'd1;
      cyc(1);
      chk("R7 data", iir, 8'h04);
      frm = 1'b1; cyc(1); frm = 1'b0;
      chk("R7 line over data", iir, 8'h06);
      lrd = 1'b1; cyc(1); lrd = 1'b0;
      chk("R7 back to data", iir, 8'h04);

      // R9 transmitter empty
      thre = 1'b0; cyc(1); thre = 1'b1; cyc(1);
      chk("R9 hidden", iir, 8'h04);
      ird = 1'b1; cyc(1); ird = 1'b0;
      lvl = 0; cyc(1);
      chk("R9 survives hidden read", iir, 8'h02);
      chk("R10 irq", {7'd0, irq}, 8'h01);
      ird = 1'b1; cyc(1); ird = 1'b0;
      chk("R9 read clears", iir, 8'h01);
      thre = 1'b0; cyc(1); thre = 1'b1; cyc(1);
      chk("R9 again", iir, 8'h02);
      thw = 1'b1; cyc(1); thw = 1'b0;
      chk("R9 write clears", iir, 8'h01);

      // R4 R5 modem
      ier = 4'b1000;
      cts = 1'b1; cyc(3);
      chk("R4 R5 cts", msr, 8'h11);
      chk("R7 modem", iir, 8'h00);
      mrd = 1'b1; cyc(1); mrd = 1'b0;
      chk("R5 read clears", msr, 8'h10);
      chk("R5 no irq", iir, 8'h01);
      ri = 1'b1; cyc(3);
      chk("R5 ri rise no delta", msr, 8'h50);
      ri = 1'b0; cyc(3);
      chk("R5 ri trailing", msr, 8'h14);
      mrd = 1'b1; cyc(1); mrd = 1'b0;
      dsr = 1'b1; dcd = 1'b1; cyc(3);
      chk("R4 R5 dsr dcd", msr, 8'hBA);
      ier = 4'b0000; cyc(1);
      chk("R10 modem masked", iir, 8'h01);
      ier = 4'b1000; mrd = 1'b1; cyc(1); mrd = 1'b0;
      chk("R5 cleared", msr, 8'hB0);

      // R8 fifo bits with nothing pending
      fen = 1'b1; cyc(1);
      chk("R8 fifo on", iir, 8'hC1);

      done = 1'b1;
      summary();
   end
endmodule